// File: doc/BRIEF.md
# Lane-Banked Physical Register File with Same-Cycle Forwarding

This block is the physical register file behind a four-lane vector ALU datapath that renames its registers. It holds 192 registers of 64 bits each: 128 stand for the architecturally visible registers and 64 are spares for renaming. A 64-bit entry can hold a double-precision value or packed SIMD data. The registers are spread over four banks, and only the matching ALU lane ever writes a given bank. The renamer sends each lane's results to physical registers in that lane's own bank. Each bank therefore needs only one write port per result latency class, not one per functional unit.

Each lane has three write channels into its bank. The first is a fast channel for single-cycle results. The second is a medium channel for results that take three to four cycles. The third is a long channel for divides and other long operations. A long result has no slot of its own. While it is presented, the block raises a global stall, so the requester holds back that lane's fast and medium writes, and the long result is written in the freed slot. Each lane has two read ports, eight in all. The read ports are combinational and forward data being written in the same cycle, so a consumer sees a fresh result with no extra cycle.

Top module: `rf_lane_file`

## Requirements
- R1: After reset, every register index 0 to 191 reads as zero on every read port.
- R2: Register index i lives in bank i mod 4 (its low two bits), at entry i div 4. A write from lane l to entry e updates register 4*e+l. A write to an entry of 48 or above changes no register.
- R3: A fast-channel write is visible on every read port from the next cycle, and it persists until that register is written again.
- R4: A medium-channel write is visible on every read port from the next cycle, and it persists until that register is written again.
- R5: When the fast and medium channels of one lane write the same entry in the same cycle and the lane has no long write, the medium data is stored and `wr_collision` is 1 in that cycle. Otherwise `wr_collision` is 0.
- R6: `stall` is 1 in exactly the cycles where at least one lane's long channel is valid, and that lane's long data is stored at its entry.
- R7: In a cycle where lane l's long channel is valid, the fast and medium writes of lane l are discarded. The writes of the other lanes still take effect.
- R8: A read of a register that is being written in the current cycle returns the incoming data. If more than one channel targets it, the long channel wins over the medium channel, and the medium channel wins over the fast channel.
- R9: The eight read ports (port k is bits k*8 and up of `rd_idx`, with data at bits k*64 and up of `rd_data`) return their registers independently and combinationally.
- R10: A read of an index from 192 to 255 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears every register |
| fast_we | input | 4 | Fast-channel write valid, one bit per lane |
| fast_entry | input | 24 | Fast-channel entry within the bank, 6 bits per lane |
| fast_data | input | 256 | Fast-channel write data, 64 bits per lane |
| med_we | input | 4 | Medium-channel write valid, one bit per lane |
| med_entry | input | 24 | Medium-channel entry, 6 bits per lane |
| med_data | input | 256 | Medium-channel write data, 64 bits per lane |
| long_we | input | 4 | Long-channel write valid, one bit per lane |
| long_entry | input | 24 | Long-channel entry, 6 bits per lane |
| long_data | input | 256 | Long-channel write data, 64 bits per lane |
| rd_idx | input | 64 | Physical register index for each of the 8 read ports, 8 bits each |
| rd_data | output | 512 | Read data for each of the 8 read ports, 64 bits each |
| stall | output | 1 | Global stall while any long result takes its bank's slot |
| wr_collision | output | 1 | Same-entry fast and medium writes seen in a lane this cycle |

## Verification
A wrong bank or entry mapping shows up as a value that reads back at a different index one cycle after it is written, so a full sweep that writes every register with a value unique to its index exposes it. A bad write priority or a lost stall discard shows up in the cycle after the conflict, as the wrong value at the contested register or as a changed neighbour in the stalled bank. A fault in forwarding appears in the same cycle as the write, before any register changes. A missed reset clear shows up on the very first reads.

// File: rtl/rf_lane_pkg.sv
package rf_lane_pkg;
   // write channel selector, also the forwarding priority order (higher wins)
   typedef enum logic [1:0] {
      CH_NONE = 2'd0,
      CH_FAST = 2'd1,
      CH_MED  = 2'd2,
      CH_LONG = 2'd3
   } wr_ch_e;

   function automatic int unsigned log2c(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank
   import rf_lane_pkg::*;
#(
   parameter int unsigned WIDTH   = 64,
   parameter int unsigned ENTRIES = 48,
   parameter int unsigned EAW     = 6,
   parameter int unsigned NRD     = 8,
   parameter bit          FORWARD = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fast_we,
   input  logic [EAW-1:0]                 fast_entry,
   input  logic [WIDTH-1:0]               fast_data,
   input  logic                           med_we,
   input  logic [EAW-1:0]                 med_entry,
   input  logic [WIDTH-1:0]               med_data,
   input  logic                           long_we,
   input  logic [EAW-1:0]                 long_entry,
   input  logic [WIDTH-1:0]               long_data,
   input  logic [NRD-1:0][EAW-1:0]        rd_entry,
   output logic [NRD-1:0][WIDTH-1:0]      rd_data,
   output logic                           collision
);
   localparam logic [EAW-1:0] LAST_E = EAW'(ENTRIES - 1);

   logic [WIDTH-1:0] mem [ENTRIES];
   logic fast_ok, med_ok, long_ok;

   // the long result takes the slot: the other channels of this bank are dropped
   assign long_ok = long_we && (long_entry <= LAST_E);
   assign fast_ok = fast_we && !long_we && (fast_entry <= LAST_E);
   assign med_ok  = med_we  && !long_we && (med_entry  <= LAST_E);

   assign collision = fast_ok && med_ok && (fast_entry == med_entry);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < int'(ENTRIES); e++) mem[e] <= '0;
      end else begin
         // later statements win: medium over fast
         if (fast_ok) mem[fast_entry] <= fast_data;
         if (med_ok)  mem[med_entry]  <= med_data;
         if (long_ok) mem[long_entry] <= long_data;
      end
   end

   for (genvar r = 0; r < int'(NRD); r++) begin : g_rd
      logic [WIDTH-1:0] stored;
      wr_ch_e           hit;

      always_comb begin
         stored = '0;
         if (rd_entry[r] <= LAST_E) stored = mem[rd_entry[r]];
      end

      if (FORWARD) begin : g_fwd
         always_comb begin
            hit = CH_NONE;
            if (fast_ok && fast_entry == rd_entry[r]) hit = CH_FAST;
            if (med_ok  && med_entry  == rd_entry[r]) hit = CH_MED;
            if (long_ok && long_entry == rd_entry[r]) hit = CH_LONG;
            unique case (hit)
               CH_FAST: rd_data[r] = fast_data;
               CH_MED:  rd_data[r] = med_data;
               CH_LONG: rd_data[r] = long_data;
               default: rd_data[r] = stored;
            endcase
         end
      end else begin : g_nofwd
         assign hit        = CH_NONE;
         assign rd_data[r] = stored;
      end
   end
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
   parameter int unsigned WIDTH = 64,
   parameter int unsigned LANES = 4,
   parameter int unsigned IW    = 8,
   parameter int unsigned BSEL  = 2,
   parameter int unsigned NREGS = 192
) (
   input  logic [IW-1:0]                 idx,
   input  logic [LANES-1:0][WIDTH-1:0]   bank_data,
   output logic [WIDTH-1:0]              data
);
   localparam logic [IW-1:0] LAST_IDX = IW'(NREGS - 1);

   always_comb begin
      data = '0;
      if (idx <= LAST_IDX) data = bank_data[idx[BSEL-1:0]];
   end
endmodule

// File: rtl/rf_lane_file.sv
module rf_lane_file
   import rf_lane_pkg::*;
#(
   parameter int unsigned WIDTH       = 64,
   parameter int unsigned LANES       = 4,
   parameter int unsigned ARCH_REGS   = 128,
   parameter int unsigned SPARE_REGS  = 64,
   parameter int unsigned RD_PER_LANE = 2,
   parameter bit          FORWARD     = 1'b1,
   localparam int unsigned NREGS   = ARCH_REGS + SPARE_REGS,
   localparam int unsigned ENTRIES = NREGS / LANES,
   localparam int unsigned BSEL    = log2c(LANES),
   localparam int unsigned IW      = log2c(NREGS),
   localparam int unsigned EAW     = log2c(ENTRIES),
   localparam int unsigned NRD     = LANES * RD_PER_LANE
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        fast_we,
   input  logic [LANES*EAW-1:0]    fast_entry,
   input  logic [LANES*WIDTH-1:0]  fast_data,
   input  logic [LANES-1:0]        med_we,
   input  logic [LANES*EAW-1:0]    med_entry,
   input  logic [LANES*WIDTH-1:0]  med_data,
   input  logic [LANES-1:0]        long_we,
   input  logic [LANES*EAW-1:0]    long_entry,
   input  logic [LANES*WIDTH-1:0]  long_data,
   input  logic [NRD*IW-1:0]       rd_idx,
   output logic [NRD*WIDTH-1:0]    rd_data,
   output logic                    stall,
   output logic                    wr_collision
);
   initial begin
      assert ((1 << BSEL) == LANES)
         else $error("LANES must be a power of two");
      assert (NREGS % LANES == 0)
         else $error("register count must split evenly over the lanes");
      assert (IW == BSEL + EAW)
         else $error("index width must equal bank select plus entry width");
      assert (RD_PER_LANE >= 1)
         else $error("at least one read port per lane");
   end

   logic [NRD-1:0][EAW-1:0]   rd_entry;
   logic [NRD-1:0][WIDTH-1:0] bank_rd [LANES];
   logic [LANES-1:0]          bank_coll;

   for (genvar k = 0; k < int'(NRD); k++) begin : g_entry
      assign rd_entry[k] = rd_idx[k*IW+BSEL +: EAW];
   end

   for (genvar l = 0; l < int'(LANES); l++) begin : g_bank
      rf_bank #(
         .WIDTH  (WIDTH),
         .ENTRIES(ENTRIES),
         .EAW    (EAW),
         .NRD    (NRD),
         .FORWARD(FORWARD)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .fast_we   (fast_we[l]),
         .fast_entry(fast_entry[l*EAW +: EAW]),
         .fast_data (fast_data[l*WIDTH +: WIDTH]),
         .med_we    (med_we[l]),
         .med_entry (med_entry[l*EAW +: EAW]),
         .med_data  (med_data[l*WIDTH +: WIDTH]),
         .long_we   (long_we[l]),
         .long_entry(long_entry[l*EAW +: EAW]),
         .long_data (long_data[l*WIDTH +: WIDTH]),
         .rd_entry  (rd_entry),
         .rd_data   (bank_rd[l]),
         .collision (bank_coll[l])
      );
   end

   for (genvar k = 0; k < int'(NRD); k++) begin : g_port
      logic [LANES-1:0][WIDTH-1:0] per_bank;
      for (genvar l = 0; l < int'(LANES); l++) begin : g_gather
         assign per_bank[l] = bank_rd[l][k];
      end
      rf_read_sel #(
         .WIDTH(WIDTH),
         .LANES(LANES),
         .IW   (IW),
         .BSEL (BSEL),
         .NREGS(NREGS)
      ) u_sel (
         .idx      (rd_idx[k*IW +: IW]),
         .bank_data(per_bank),
         .data     (rd_data[k*WIDTH +: WIDTH])
      );
   end

   assign stall        = |long_we;
   assign wr_collision = |bank_coll;
endmodule

// File: rtl/rf_lane_file_chk.sv
module rf_lane_file_chk #(
   parameter int unsigned WIDTH       = 64,
   parameter int unsigned LANES       = 4,
   parameter int unsigned NREGS       = 192,
   parameter int unsigned BSEL        = 2,
   parameter int unsigned IW          = 8,
   parameter int unsigned EAW         = 6,
   parameter int unsigned NRD         = 8,
   parameter int unsigned ENTRIES     = 48,
   parameter bit          FORWARD     = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES-1:0]        fast_we,
   input logic [LANES*EAW-1:0]    fast_entry,
   input logic [LANES*WIDTH-1:0]  fast_data,
   input logic [LANES-1:0]        med_we,
   input logic [LANES*EAW-1:0]    med_entry,
   input logic [LANES*WIDTH-1:0]  med_data,
   input logic [LANES-1:0]        long_we,
   input logic [LANES*EAW-1:0]    long_entry,
   input logic [LANES*WIDTH-1:0]  long_data,
   input logic [NRD*IW-1:0]       rd_idx,
   input logic [NRD*WIDTH-1:0]    rd_data,
   input logic                    stall,
   input logic                    wr_collision
);
   localparam logic [IW-1:0]  LAST_IDX = IW'(NREGS - 1);
   localparam logic [EAW-1:0] LAST_E   = EAW'(ENTRIES - 1);

   for (genvar k = 0; k < int'(NRD); k++) begin : g_port
      logic [IW-1:0]    idx;
      logic [BSEL-1:0]  bank;
      logic [EAW-1:0]   ent;
      logic [WIDTH-1:0] dat;
      assign idx  = rd_idx[k*IW +: IW];
      assign bank = idx[BSEL-1:0];
      assign ent  = idx[IW-1:BSEL];
      assign dat  = rd_data[k*WIDTH +: WIDTH];

      assert_range_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (idx > LAST_IDX) |-> (dat == '0));

      if (FORWARD) begin : g_fwd
         assert_long_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (idx <= LAST_IDX && long_we[bank] && long_entry[bank*EAW +: EAW] == ent
             && ent <= LAST_E) |-> (dat == long_data[bank*WIDTH +: WIDTH]));
      end
   end

   for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      assert_collision_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (fast_we[l] && med_we[l] && !long_we[l]
          && fast_entry[l*EAW +: EAW] == med_entry[l*EAW +: EAW]
          && med_entry[l*EAW +: EAW] <= LAST_E) |-> wr_collision);

      assert_long_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
         long_we[l] |-> stall);
   end

   // medium data survives a same-entry conflict in lane 0 (read back on port 0)
   assert_med_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fast_we[0] && med_we[0] && !long_we[0]
             && fast_entry[EAW-1:0] == med_entry[EAW-1:0] && med_entry[EAW-1:0] <= LAST_E)
       && rd_idx[IW-1:0] == IW'({$past(med_entry[EAW-1:0]), {BSEL{1'b0}}})
       && !fast_we[0] && !med_we[0] && !long_we[0])
      |-> (rd_data[WIDTH-1:0] == $past(med_data[WIDTH-1:0])));

   // a long write to lane 0 lands and is read back the next cycle on port 0
   assert_long_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(long_we[0] && long_entry[EAW-1:0] <= LAST_E)
       && rd_idx[IW-1:0] == IW'({$past(long_entry[EAW-1:0]), {BSEL{1'b0}}})
       && !fast_we[0] && !med_we[0] && !long_we[0])
      |-> (rd_data[WIDTH-1:0] == $past(long_data[WIDTH-1:0])));
endmodule

bind rf_lane_file rf_lane_file_chk #(
   .WIDTH  (WIDTH),
   .LANES  (LANES),
   .NREGS  (NREGS),
   .BSEL   (BSEL),
   .IW     (IW),
   .EAW    (EAW),
   .NRD    (NRD),
   .ENTRIES(ENTRIES),
   .FORWARD(FORWARD)
) u_chk (.*);

// File: tb/test_rf_lane_file.sv
module test_rf_lane_file;
   localparam int PERIOD = 10;
   localparam int LN = 4, EW = 6, W = 64, IWB = 8, NP = 8, NR = 192;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LN-1:0]     fast_we = '0, med_we = '0, long_we = '0;
   logic [LN*EW-1:0]  fast_entry = '0, med_entry = '0, long_entry = '0;
   logic [LN*W-1:0]   fast_data = '0, med_data = '0, long_data = '0;
   logic [NP*IWB-1:0] rd_idx = '0;
   logic [NP*W-1:0]   rd_data;
   logic              stall, wr_collision;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] model [NR];

   always #(PERIOD/2) clk = ~clk;

   rf_lane_file i_rf_lane_file (
      .clk(clk), .rst_n(rst_n),
      .fast_we(fast_we), .fast_entry(fast_entry), .fast_data(fast_data),
      .med_we(med_we), .med_entry(med_entry), .med_data(med_data),
      .long_we(long_we), .long_entry(long_entry), .long_data(long_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .stall(stall), .wr_collision(wr_collision)
   );

   function automatic logic [W-1:0] pat(input int i, input logic [31:0] salt);
      return {(32'(i) * 32'h9E3779B1) ^ salt, ~(32'(i) + salt)};
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic idle;
      fast_we = '0; med_we = '0; long_we = '0;
   endtask

   // sweep all registers through the 8 ports against the model
   task automatic read_all(input string req);
      for (int base = 0; base < NR; base += NP) begin
         for (int k = 0; k < NP; k++) rd_idx[k*IWB +: IWB] = 8'(base + k);
         #1;
         for (int k = 0; k < NP; k++) chk(req, rd_data[k*W +: W], model[base + k]);
      end
   endtask

   task automatic read1(input string req, input int port, input int idx, input logic [W-1:0] exp);
      rd_idx[port*IWB +: IWB] = 8'(idx);
      #1;
      chk(req, rd_data[port*W +: W], exp);
   endtask

   initial begin
      #(PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) model[i] = '0;
      #(PERIOD*3);
      rst_n = 1'b1;
      tick;

      // R1 R9: all zero after reset
      read_all("R1_reset_zero");
      chk("R6_no_stall_idle", {63'd0, stall}, 64'd0);

      // R3 R2 R8: fast sweep, every lane writes entry e; forward checked same cycle
      for (int e = 0; e < 48; e++) begin
         for (int l = 0; l < LN; l++) begin
            fast_we[l] = 1'b1;
            fast_entry[l*EW +: EW] = 6'(e);
            fast_data[l*W +: W] = pat(4*e + l, 32'h1111_0000);
            rd_idx[l*IWB +: IWB] = 8'(4*e + l);
         end
         #1;
         for (int l = 0; l < LN; l++)
            chk("R8_fast_forward", rd_data[l*W +: W], pat(4*e + l, 32'h1111_0000));
         chk("R5_no_collision", {63'd0, wr_collision}, 64'd0);
         tick;
         for (int l = 0; l < LN; l++) model[4*e + l] = pat(4*e + l, 32'h1111_0000);
      end
      idle;
      read_all("R3_fast_persist_R2_map");

      // R4: medium channel rewrites odd entries
      for (int e = 1; e < 48; e += 2) begin
         for (int l = 0; l < LN; l++) begin
            med_we[l] = 1'b1;
            med_entry[l*EW +: EW] = 6'(e);
            med_data[l*W +: W] = pat(4*e + l, 32'h2222_0000);
         end
         tick;
         for (int l = 0; l < LN; l++) model[4*e + l] = pat(4*e + l, 32'h2222_0000);
      end
      idle;
      read_all("R4_med_persist");

      // R5 R8: lane 2 fast and medium hit entry 5 together
      fast_we[2] = 1'b1; fast_entry[2*EW +: EW] = 6'd5; fast_data[2*W +: W] = 64'hAAAA_0000_0000_0001;
      med_we[2]  = 1'b1; med_entry[2*EW +: EW]  = 6'd5; med_data[2*W +: W]  = 64'hBBBB_0000_0000_0002;
      #1;
      chk("R5_collision_flag", {63'd0, wr_collision}, 64'd1);
      read1("R8_med_over_fast_forward", 3, 22, 64'hBBBB_0000_0000_0002);
      tick;
      idle;
      model[22] = 64'hBBBB_0000_0000_0002;
      #1;
      chk("R5_collision_clears", {63'd0, wr_collision}, 64'd0);
      read1("R5_med_wins_stored", 0, 22, 64'hBBBB_0000_0000_0002);

      // R6 R7 R8: lane 1 long write with its fast/med dropped; lane 3 fast proceeds
      long_we[1] = 1'b1; long_entry[1*EW +: EW] = 6'd7; long_data[1*W +: W] = 64'hCCCC_0000_0000_0003;
      fast_we[1] = 1'b1; fast_entry[1*EW +: EW] = 6'd8; fast_data[1*W +: W] = 64'hDEAD_0000_0000_0004;
      med_we[1]  = 1'b1; med_entry[1*EW +: EW]  = 6'd9; med_data[1*W +: W]  = 64'hDEAD_0000_0000_0005;
      fast_we[3] = 1'b1; fast_entry[3*EW +: EW] = 6'd10; fast_data[3*W +: W] = 64'hEEEE_0000_0000_0006;
      #1;
      chk("R6_stall_high", {63'd0, stall}, 64'd1);
      read1("R8_long_forward", 1, 29, 64'hCCCC_0000_0000_0003);
      tick;
      idle;
      model[29] = 64'hCCCC_0000_0000_0003;
      model[43] = 64'hEEEE_0000_0000_0006;
      #1;
      chk("R6_stall_low", {63'd0, stall}, 64'd0);
      read_all("R7_stalled_lane_dropped_R6_long_stored");

      // R8: long and fast of lane 0 on the same entry, long forwarded and stored
      long_we[0] = 1'b1; long_entry[0 +: EW] = 6'd3; long_data[0 +: W] = 64'h1234_5678_9ABC_DEF0;
      fast_we[0] = 1'b1; fast_entry[0 +: EW] = 6'd3; fast_data[0 +: W] = 64'h0FED_CBA9_8765_4321;
      read1("R8_long_over_fast_forward", 6, 12, 64'h1234_5678_9ABC_DEF0);
      tick;
      idle;
      model[12] = 64'h1234_5678_9ABC_DEF0;
      read1("R8_long_stored", 7, 12, 64'h1234_5678_9ABC_DEF0);

      // R10: out of range indexes read zero
      for (int base = NR; base < 256; base += NP) begin
         for (int k = 0; k < NP; k++) rd_idx[k*IWB +: IWB] = 8'(base + k);
         #1;
         for (int k = 0; k < NP; k++) chk("R10_out_of_range", rd_data[k*W +: W], 64'd0);
      end

      // R2: writes to entries 48..63 change nothing
      for (int e = 48; e < 64; e++) begin
         for (int l = 0; l < LN; l++) begin
            fast_we[l] = 1'b1; fast_entry[l*EW +: EW] = 6'(e); fast_data[l*W +: W] = pat(e, 32'h5555_0000);
            med_we[l]  = 1'b0;
         end
         tick;
      end
      idle;
      read_all("R2_bad_entry_discarded");

      // R1: reset again clears everything
      rst_n = 1'b0;
      #(PERIOD*2);
      rst_n = 1'b1;
      tick;
      for (int i = 0; i < NR; i++) model[i] = '0;
      read_all("R1_reset_again");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule